// File: doc/BRIEF.md
# Staircase Stall-Pattern Resolver

This block is called after an iterative hard-decision decode of a pair of adjacent staircase blocks has stopped making progress. At that point no component decoder is flipping bits, yet some constraints still fail. Either no pass produced a flip, or the pass limit was reached with nonzero syndromes. The caller hands over two indicator vectors: one bit per failing horizontal constraint and one bit per failing vertical constraint. The window is arranged as an N×N bit array, where rows are the horizontal component words and columns are the vertical ones. The block reads the stored hard decisions from an external array. It inverts every bit that lies on both a failing row and a failing column, and writes each corrected row back. For a small error pattern, in which each involved row and column carries exactly one more error than a component word can repair, every error sits at such a crossing, so one sweep clears it.

The component code is an extended Hamming code of length N = 2^M, which corrects one error (t = 1). A minimal stall therefore covers two rows and two columns. During the same single sweep, the block recomputes every row and column syndrome from the corrected data. It reports the new failing-row and failing-column vectors and a flag that is set only when every constraint holds. The sweep handles one row per clock. If too many rows or too many columns are flagged, inverting the crossings would most likely add errors, so the sweep only re-evaluates the syndromes and writes nothing.

Top module: `stall_resolver`

## Requirements
- R1: While reset (synchronous, active-low) is applied and afterwards until a start is accepted, busy_o, done_o, resolved_o, mask_skipped_o and wr_en_o are all 0.
- R2: A start_i seen while idle latches row_fail_i and col_fail_i and raises busy_o. A start_i seen while busy is ignored: the indicators that were latched first decide the result.
- R3: The correction for bit c of row r is row_fail_i[r] AND col_fail_i[c]. Row r is read at address r, and one clock later, after the read returns, it is written back to address r as the read data XOR that correction. Rows are handled in order 0..N-1, one per clock.
- R4: If more than FLIP_LIMIT (default 4) row indicators are set, or more than FLIP_LIMIT column indicators are set, nothing is written and mask_skipped_o is 1 at done. When exactly FLIP_LIMIT indicators are set, the correction is applied.
- R5: Bit j of a word has position index j. The syndrome of a word is the XOR of the M-bit indices of its set bits, concatenated with the XOR of all its bits. A column's word takes bit c of each row, with the row number as the position index. At done, row_bad_o[r] and col_bad_o[c] are 1 exactly when that syndrome is nonzero after correction.
- R6: At done, resolved_o is 1 exactly when every row and column syndrome is zero after correction.
- R7: done_o is a single-cycle pulse. It rises N+2 rising edges after the edge that accepted start, and busy_o is 0 while done_o is 1.
- R8: On data that was a valid array of codewords, any single error, and any 2-row by 2-column stall, is removed when the caller passes the true failing-constraint vectors, and resolved_o is then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only while idle |
| row_fail_i | input | N | Failing row-constraint indicators |
| col_fail_i | input | N | Failing column-constraint indicators |
| rd_en_o | output | 1 | Array read enable |
| rd_addr_o | output | M | Array read row address |
| rd_data_i | input | N | Array read data, one cycle after the address |
| wr_en_o | output | 1 | Array write enable |
| wr_addr_o | output | M | Array write row address |
| wr_data_o | output | N | Corrected row data |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| resolved_o | output | 1 | All syndromes zero after the last sweep |
| mask_skipped_o | output | 1 | Last sweep wrote nothing because of the limit |
| row_bad_o | output | N | Failing rows after the last sweep |
| col_bad_o | output | N | Failing columns after the last sweep |

## Verification
Every 2×2 stall position, on both an all-zero and an all-one codeword array, checks the cases where the crossings cover the error set exactly. Every single-error position checks the degenerate one-crossing case. Partial indicator sets on the same stalls leave residual errors, which separates correct syndrome recomputation from a flag that is simply forced high. Square error patterns of size FLIP_LIMIT and FLIP_LIMIT+1, together with a start re-asserted while busy, check the threshold edge and whether the latched indicators or the live ones drive the result.

// File: rtl/sr_pkg.sv
// Shared types for the stall resolver.
// Assumes: nothing beyond the standard language.
package sr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sr_state_e;
endpackage

// File: rtl/sr_limit_gate.sv
// Decides whether the crossing mask may be applied: it counts the set
// row and column indicators and allows the correction only when neither
// count exceeds LIMIT.
// Assumes: the inputs are stable while the result is sampled.
module sr_limit_gate #(
    parameter int N     = 8,
    parameter int LIMIT = 4
) (
    input  logic [N-1:0] row_ind,
    input  logic [N-1:0] col_ind,
    output logic         allow
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] row_cnt;
    logic [CW-1:0] col_cnt;

    // Population counts of both indicator vectors.
    always_comb begin
        row_cnt = '0;
        col_cnt = '0;
        for (int i = 0; i < N; i++) begin
            row_cnt = row_cnt + CW'(row_ind[i]);
            col_cnt = col_cnt + CW'(col_ind[i]);
        end
    end

    // Threshold comparison.
    always_comb begin
        allow = (int'(row_cnt) <= LIMIT) && (int'(col_cnt) <= LIMIT);
    end
endmodule

// File: rtl/sr_word_check.sv
// Extended Hamming syndrome of one N-bit word, N = 2**M. The syndrome is
// the XOR of the indices of the set bits, with the overall parity above
// it. A nonzero syndrome marks the word as failing.
// Assumes: purely combinational use.
module sr_word_check #(
    parameter int M = 3
) (
    input  logic [(1<<M)-1:0] word,
    output logic              bad
);
    localparam int N  = 1 << M;
    localparam int SW = M + 1;

    logic [SW-1:0] syn;

    // Accumulate the index XOR and the parity over all set bits.
    always_comb begin
        syn = '0;
        for (int j = 0; j < N; j++) begin
            if (word[j]) begin
                syn = syn ^ {1'b1, j[M-1:0]};
            end
        end
        bad = |syn;
    end
endmodule

// File: rtl/sr_col_accum.sv
// Running column syndromes. Each column holds its own register, which is
// updated with every corrected row that streams past, using the row
// number as the position index.
// Assumes: rows arrive one per enabled cycle; clr comes before the first.
module sr_col_accum #(
    parameter int M = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [M-1:0]      row_idx,
    input  logic [(1<<M)-1:0] word,
    output logic [(1<<M)-1:0] col_bad
);
    localparam int N  = 1 << M;
    localparam int SW = M + 1;

    for (genvar c = 0; c < N; c++) begin : g_col
        logic [SW-1:0] syn;

        // Clear on a new sweep, fold in set bits of each corrected row.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                syn <= '0;
            end else if (clr) begin
                syn <= '0;
            end else if (en && word[c]) begin
                syn <= syn ^ {1'b1, row_idx};
            end
        end

        assign col_bad[c] = |syn;
    end
endmodule

// File: rtl/stall_resolver.sv
// Stall-pattern resolver for one staircase window held as an N x N array.
// It latches the failing row and column indicators at start. It then
// streams the rows in order through a read port with one cycle of
// latency, inverts the bits on failing-row/failing-column crossings, and
// writes each row back one cycle after its read. In the same sweep it
// rebuilds all row and column syndromes. The correction is suppressed
// when more than FLIP_LIMIT rows or columns are flagged.
// Assumes: the external array returns rd_data_i on the clock after
// rd_addr_o, and a write does not disturb a read of a different row in
// the same cycle.
module stall_resolver
    import sr_pkg::*;
#(
    parameter int M          = 3,
    parameter int FLIP_LIMIT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [(1<<M)-1:0]  row_fail_i,
    input  logic [(1<<M)-1:0]  col_fail_i,
    output logic               rd_en_o,
    output logic [M-1:0]       rd_addr_o,
    input  logic [(1<<M)-1:0]  rd_data_i,
    output logic               wr_en_o,
    output logic [M-1:0]       wr_addr_o,
    output logic [(1<<M)-1:0]  wr_data_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               resolved_o,
    output logic               mask_skipped_o,
    output logic [(1<<M)-1:0]  row_bad_o,
    output logic [(1<<M)-1:0]  col_bad_o
);
    localparam int N  = 1 << M;
    localparam int CW = M + 1;

    sr_state_e      state;
    logic [N-1:0]   row_q;
    logic [N-1:0]   col_q;
    logic           apply_q;
    logic [CW-1:0]  rd_cnt;
    logic           vld;
    logic [M-1:0]   wr_row;
    logic [N-1:0]   rowbad_acc;

    logic           accept;
    logic           allow;
    logic           issuing;
    logic [N-1:0]   fixed_row;
    logic           fixed_bad;
    logic [N-1:0]   colbad_now;
    logic           last_row;

    // Threshold on the live indicators, sampled when start is accepted.
    sr_limit_gate #(
        .N     (N),
        .LIMIT (FLIP_LIMIT)
    ) u_gate (
        .row_ind (row_fail_i),
        .col_ind (col_fail_i),
        .allow   (allow)
    );

    // Start is taken only while idle.
    assign accept  = (state == ST_IDLE) && start_i;
    // Reads are issued while rows remain to be fetched.
    assign issuing = (state == ST_RUN) && (rd_cnt < CW'(N));
    assign last_row = vld && (wr_row == M'(N - 1));

    // Apply the crossing mask to the row that just came back.
    always_comb begin
        fixed_row = rd_data_i;
        if (apply_q && row_q[wr_row]) begin
            fixed_row = rd_data_i ^ col_q;
        end
    end

    // Row syndrome of the corrected row.
    sr_word_check #(.M(M)) u_rowchk (
        .word (fixed_row),
        .bad  (fixed_bad)
    );

    // Column syndromes built from the corrected rows.
    sr_col_accum #(.M(M)) u_cols (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .en      (vld),
        .row_idx (wr_row),
        .word    (fixed_row),
        .col_bad (colbad_now)
    );

    // Memory port drive.
    assign rd_en_o   = issuing;
    assign rd_addr_o = rd_cnt[M-1:0];
    assign wr_en_o   = vld && apply_q;
    assign wr_addr_o = wr_row;
    assign wr_data_o = fixed_row;
    assign busy_o    = (state != ST_IDLE);

    // Sweep sequencing: idle, row stream, final evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            apply_q <= 1'b0;
            rd_cnt  <= '0;
            vld     <= 1'b0;
            wr_row  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    vld <= 1'b0;
                    if (accept) begin
                        row_q   <= row_fail_i;
                        col_q   <= col_fail_i;
                        apply_q <= allow;
                        rd_cnt  <= '0;
                        state   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (issuing) begin
                        rd_cnt <= rd_cnt + 1'b1;
                    end
                    vld    <= issuing;
                    wr_row <= rd_cnt[M-1:0];
                    if (last_row) begin
                        state <= ST_FIN;
                        vld   <= 1'b0;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Per-row failure capture during the stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rowbad_acc <= '0;
        end else if (accept) begin
            rowbad_acc <= '0;
        end else if (vld) begin
            rowbad_acc[wr_row] <= fixed_bad;
        end
    end

    // Result registers and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o         <= 1'b0;
            resolved_o     <= 1'b0;
            mask_skipped_o <= 1'b0;
            row_bad_o      <= '0;
            col_bad_o      <= '0;
        end else begin
            done_o <= 1'b0;
            if (state == ST_FIN) begin
                done_o         <= 1'b1;
                resolved_o     <= ~|rowbad_acc && ~|colbad_now;
                mask_skipped_o <= ~apply_q;
                row_bad_o      <= rowbad_acc;
                col_bad_o      <= colbad_now;
            end
        end
    end
endmodule

// File: rtl/sr_checker.sv
// Temporal checks on the stall resolver, attached by bind.
// Assumes: it observes the latched column indicators and the apply
// decision of the resolver.
module sr_checker #(
    parameter int M = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              busy_o,
    input  logic              done_o,
    input  logic              wr_en_o,
    input  logic [M-1:0]      wr_addr_o,
    input  logic [(1<<M)-1:0] wr_data_o,
    input  logic [(1<<M)-1:0] rd_data_i,
    input  logic [(1<<M)-1:0] col_q,
    input  logic              apply_q,
    input  logic              resolved_o,
    input  logic [(1<<M)-1:0] row_bad_o,
    input  logic [(1<<M)-1:0] col_bad_o
);
    assert_idle_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !wr_en_o);

    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_flip_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (((wr_data_o ^ rd_data_i) & ~col_q) == '0));

    assert_wr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == M'($past(wr_addr_o) + 1'b1)));

    assert_skip_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !apply_q) |-> !wr_en_o);

    assert_resolved_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (resolved_o == ((row_bad_o == '0) && (col_bad_o == '0))));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind stall_resolver sr_checker #(.M(M)) u_sr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .rd_data_i  (rd_data_i),
    .col_q      (col_q),
    .apply_q    (apply_q),
    .resolved_o (resolved_o),
    .row_bad_o  (row_bad_o),
    .col_bad_o  (col_bad_o)
);

// File: tb/tb_stall_resolver.sv
`timescale 1ns/1ps
module tb_stall_resolver;
    localparam int M     = 3;
    localparam int N     = 8;
    localparam int LIMIT = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [N-1:0] row_fail_i = '0;
    logic [N-1:0] col_fail_i = '0;
    logic         rd_en_o;
    logic [M-1:0] rd_addr_o;
    logic [N-1:0] rd_data_i;
    logic         wr_en_o;
    logic [M-1:0] wr_addr_o;
    logic [N-1:0] wr_data_o;
    logic         busy_o, done_o, resolved_o, mask_skipped_o;
    logic [N-1:0] row_bad_o, col_bad_o;

    logic [N-1:0] mem [N];
    logic [N-1:0] gold [N];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    stall_resolver #(.M(M), .FLIP_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .row_fail_i(row_fail_i), .col_fail_i(col_fail_i),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .busy_o(busy_o), .done_o(done_o), .resolved_o(resolved_o),
        .mask_skipped_o(mask_skipped_o), .row_bad_o(row_bad_o), .col_bad_o(col_bad_o)
    );

    // Array model with one cycle of read latency.
    always @(posedge clk) begin
        rd_data_i <= mem[rd_addr_o];
        if (wr_en_o) mem[wr_addr_o] <= wr_data_o;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit word_bad(input logic [N-1:0] w);
        logic [M:0] s = '0;
        for (int j = 0; j < N; j++) if (w[j]) s = s ^ {1'b1, 3'(j)};
        return s != '0;
    endfunction

    function automatic logic [N-1:0] col_of(input int c);
        logic [N-1:0] v;
        for (int r = 0; r < N; r++) v[r] = gold[r][c];
        return v;
    endfunction

    function automatic logic [N-1:0] rows_bad_gold();
        logic [N-1:0] v;
        for (int r = 0; r < N; r++) v[r] = word_bad(gold[r]);
        return v;
    endfunction

    function automatic logic [N-1:0] cols_bad_gold();
        logic [N-1:0] v;
        for (int c = 0; c < N; c++) v[c] = word_bad(col_of(c));
        return v;
    endfunction

    // Fill both the array and the golden copy with a constant codeword array.
    task automatic load(input bit ones);
        for (int r = 0; r < N; r++) begin
            mem[r]  = ones ? '1 : '0;
            gold[r] = ones ? '1 : '0;
        end
    endtask

    task automatic inject(input int r, input int c);
        mem[r][c]  = ~mem[r][c];
        gold[r][c] = ~gold[r][c];
    endtask

    // Run one sweep; hold>1 re-asserts start with other indicators while busy.
    task automatic run(input logic [N-1:0] rf, input logic [N-1:0] cf, input int hold, input string tag);
        bit apply;
        int lat;
        logic [N-1:0] erb, ecb;
        apply = ($countones(rf) <= LIMIT) && ($countones(cf) <= LIMIT);
        if (apply) for (int r = 0; r < N; r++) if (rf[r]) gold[r] = gold[r] ^ cf;
        erb = rows_bad_gold();
        ecb = cols_bad_gold();
        @(negedge clk);
        row_fail_i = rf; col_fail_i = cf; start_i = 1'b1;
        @(negedge clk);
        lat = 1;
        if (hold > 1) begin
            row_fail_i = '1; col_fail_i = '1;
            repeat (hold - 1) begin
                @(negedge clk);
                lat++;
            end
        end
        start_i = 1'b0; row_fail_i = '0; col_fail_i = '0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == N + 3, {tag, " R7 latency"}, lat, N + 3);
        chk(!busy_o, {tag, " R7 busy at done"}, busy_o, 0);
        chk(mask_skipped_o == !apply, {tag, " R4 skip flag"}, mask_skipped_o, !apply);
        for (int r = 0; r < N; r++)
            chk(mem[r] === gold[r], {tag, " R3 row content"}, mem[r], gold[r]);
        chk(row_bad_o == erb, {tag, " R5 row indicators"}, row_bad_o, erb);
        chk(col_bad_o == ecb, {tag, " R5 col indicators"}, col_bad_o, ecb);
        chk(resolved_o == (erb == 0 && ecb == 0), {tag, " R6 resolved"}, resolved_o, (erb == 0 && ecb == 0));
        @(negedge clk);
        chk(!done_o, {tag, " R7 pulse width"}, done_o, 0);
    endtask

    function automatic logic [N-1:0] bits2(input int a, input int b);
        logic [N-1:0] v = '0;
        v[a] = 1'b1; v[b] = 1'b1;
        return v;
    endfunction

    initial begin
        bit base;
        load(1'b0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o && !resolved_o && !mask_skipped_o && !wr_en_o,
            "R1 reset outputs", {busy_o, done_o, resolved_o, mask_skipped_o, wr_en_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !wr_en_o, "R1 idle after reset", {busy_o, wr_en_o}, 0);

        // R6: clean array, no indicators
        run('0, '0, 1, "clean");

        // R8: every single-error position
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                load(r[0]);
                inject(r, c);
                run(rows_bad_gold(), cols_bad_gold(), 1, "R8 single");
            end

        // R8 / R3: every minimal 2x2 stall, alternating base codeword
        base = 1'b0;
        for (int r1 = 0; r1 < N; r1++)
            for (int r2 = r1 + 1; r2 < N; r2++)
                for (int c1 = 0; c1 < N; c1++)
                    for (int c2 = c1 + 1; c2 < N; c2++) begin
                        base = ~base;
                        load(base);
                        inject(r1, c1); inject(r1, c2); inject(r2, c1); inject(r2, c2);
                        run(bits2(r1, r2), bits2(c1, c2), 1, "R8 stall");
                    end

        // R5: partial indicators leave residual errors
        for (int k = 0; k < N - 1; k++) begin
            load(1'b0);
            inject(k, 1); inject(k, 6); inject(k + 1, 1); inject(k + 1, 6);
            run(bits2(k, k), bits2(1, 6), 1, "R5 partial");
        end

        // R4: exactly LIMIT rows/cols applied (indices 0,1,2,4)
        load(1'b0);
        foreach (mem[r]) if (r inside {0, 1, 2, 4}) begin
            inject(r, 0); inject(r, 1); inject(r, 2); inject(r, 4);
        end
        run(8'b0001_0111, 8'b0001_0111, 1, "R4 at limit");

        // R4: LIMIT+1 rows/cols skipped (indices 0,1,2,3,5)
        load(1'b1);
        foreach (mem[r]) if (r inside {0, 1, 2, 3, 5}) begin
            inject(r, 0); inject(r, 1); inject(r, 2); inject(r, 3); inject(r, 5);
        end
        run(8'b0010_1111, 8'b0010_1111, 1, "R4 over limit");

        // R4: only rows over the limit
        load(1'b0);
        inject(0, 0); inject(0, 1); inject(1, 0); inject(1, 1);
        run(8'b0011_1111, bits2(0, 1), 1, "R4 rows over");

        // R2: start held while busy with other indicators is ignored
        load(1'b1);
        inject(2, 3); inject(2, 5); inject(6, 3); inject(6, 5);
        run(bits2(2, 6), bits2(3, 5), 4, "R2 start while busy");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule